// File: doc/BRIEF.md
# Double-buffered crosspoint switch controller

This block keeps the on/off state of a 12-by-8 crosspoint array: 96 switch enables, one for each pairing of an X line (0 to 11) with a Y line (0 to 7). A serial front end hands it 16-bit command words, each with a one-cycle strobe. An ordinary command opens or closes one switch in a pending register. Its trailing load flag then decides what happens next. With the flag set, the whole pending register is copied to the active outputs at once. With it clear, the new state stays pending, so a group of switches can later change in the same cycle.

The X-select field is sparse. Four of its sixteen codes are reserved and never touch a switch. The same reserved codes also carry a readback-select byte. When a valid select arrives, the block latches the eight active states of one X line into a status byte, which the front end shifts back out. An active-low reset pin clears the pending register, the active register and the status byte, and it blocks every command while it is held low. Switch `x*8+y` of `sw_active` is the enable joining X line `x` to Y line `y`.

Top module: `xbar_switch_ctrl`

## Requirements
- R1: A command word is taken on a rising clock edge when `cmd_valid` is 1. Bit 15 is the switch value (1 closes, 0 opens), bits 14:11 are the X code, bits 10:8 are the Y code, bits 7:1 are ignored and bit 0 is the load flag. Y code `y` selects Y line `y`. The addressed switch is `sw_active[x*8+y]`.
- R2: X codes 0 to 5 select X lines 0 to 5. X codes 8 to 13 select X lines 6 to 11.
- R3: A word whose X code is 6, 7, 14 or 15 changes neither pending nor active switch state, whatever its value and load bits are.
- R4: A normal command changes only the addressed pending bit. All other pending bits keep their values.
- R5: If the load flag is 1, the active outputs equal the pending register, including that word's own write, from the edge that accepts the word. If the load flag is 0, the active outputs do not change.
- R6: Several words sent with load 0, followed by a final word with load 1, make every one of their switches change in the same cycle.
- R7: While `rst_n` is low, the pending bits, the active bits and the status byte are 0, and accepted commands are ignored. After release, a load word shows that pending state was cleared.
- R8: A readback-select byte sits in command bits 15:8. Its bit 7 is 0 and its bits 5, 4 and 2 are 1. Its bit 3 is X-index bit 0, its bit 6 is X-index bit 1, and its bits 1:0 hold the X index divided by 4 (value 0 to 2). Examples: 0x34 selects X0, 0x3C selects X1, 0x7E selects X11. On the edge that accepts such a word, `status_byte` bit n takes active switch (X, Yn), with 1 meaning closed.
- R9: For a readback-select word, bits 7:0 are ignored: no switch changes even when bit 0 is 1. A reserved-code word that is not a valid select leaves the status byte unchanged. This includes a byte with bits 1:0 equal to 3.
- R10: `status_byte` keeps its value through normal switch commands and idle cycles, until the next valid readback-select or reset.
- R11: While `cmd_valid` is 0, neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, clears all state |
| cmd_word | input | 16 | Command word from the serial front end |
| cmd_valid | input | 1 | One-cycle strobe qualifying `cmd_word` |
| sw_active | output | 96 | Active switch enables, bit x*8+y |
| status_byte | output | 8 | Latched readback row, bit n is Y line n |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a switch write and the load transfer inside one word. The bench sends load words that address a switch whose pending value differs from its active value, and it requires the new value to show on `sw_active` at the very next sample, not one transfer later. The second pair is reset and a command strobe. The bench holds `cmd_valid` high with a closing load word while `rst_n` is low, and it requires the outputs to stay zero. A load word after release must then confirm that the pending register was emptied too.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

   localparam int CMD_W  = 16;
   localparam int XSEL_W = 4;
   localparam int YSEL_W = 3;
   localparam int ROW_W  = 4;

   // X codes 6, 7, 14 and 15 (bits 2:1 both set) carry no switch row
   function automatic logic xsel_reserved(input logic [XSEL_W-1:0] code);
      return code[2] & code[1];
   endfunction

   // Fold the sparse X code onto a dense row index 0..11
   function automatic logic [ROW_W-1:0] xsel_row(input logic [XSEL_W-1:0] code);
      return code[3] ? ROW_W'(code - XSEL_W'(2)) : ROW_W'(code);
   endfunction

endpackage

// File: rtl/xbar_cmd_decode.sv
module xbar_cmd_decode
   import xbar_pkg::*;
(
   input  logic [CMD_W-1:0]  word,
   input  logic              valid,
   output logic              wr_en,
   output logic              wr_val,
   output logic              wr_load,
   output logic [ROW_W-1:0]  wr_row,
   output logic [YSEL_W-1:0] wr_col,
   output logic              rb_en,
   output logic [ROW_W-1:0]  rb_row
);

   logic [XSEL_W-1:0] xcode;
   logic              xres;
   logic              rb_shape;
   logic              dc_unused;

   assign xcode     = word[14:11];
   assign xres      = xsel_reserved(xcode);
   assign dc_unused = ^word[7:1];

   // select byte: bit7 = 0, bits 5,4,2 = 1, quotient field below 3
   assign rb_shape  = ~word[15] & word[13] & word[12] & word[10] & ~(word[9] & word[8]);

   assign wr_en   = valid & ~xres;
   assign wr_val  = word[15];
   assign wr_load = word[0];
   assign wr_row  = xsel_row(xcode);
   assign wr_col  = word[10:8];

   assign rb_en   = valid & xres & rb_shape;
   assign rb_row  = {word[9:8], word[14], word[11]};

endmodule

// File: rtl/xbar_switch_bank.sv
module xbar_switch_bank
   import xbar_pkg::*;
#(
   parameter int NUM_X       = 12,
   parameter int NUM_Y       = 8,
   parameter bit ASYNC_RESET = 1'b1,
   localparam int NUM_SW     = NUM_X * NUM_Y
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_val,
   input  logic              wr_load,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [YSEL_W-1:0] wr_col,
   output logic [NUM_SW-1:0] active
);

   logic [NUM_SW-1:0] pending;
   logic [NUM_SW-1:0] pend_nx;
   logic [NUM_SW-1:0] act_nx;

   for (genvar r = 0; r < NUM_X; r++) begin : g_row
      for (genvar c = 0; c < NUM_Y; c++) begin : g_col
         logic hit;
         assign hit = wr_en && (wr_row == ROW_W'(r)) && (wr_col == YSEL_W'(c));
         assign pend_nx[r*NUM_Y + c] = hit ? wr_val : pending[r*NUM_Y + c];
      end
   end

   // forward next pending so a load word carries its own write
   assign act_nx = (wr_en && wr_load) ? pend_nx : active;

   if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pending <= '0;
            active  <= '0;
         end else begin
            pending <= pend_nx;
            active  <= act_nx;
         end
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pending <= '0;
            active  <= '0;
         end else begin
            pending <= pend_nx;
            active  <= act_nx;
         end
      end
   end

endmodule

// File: rtl/xbar_readback.sv
module xbar_readback
   import xbar_pkg::*;
#(
   parameter int NUM_X       = 12,
   parameter int NUM_Y       = 8,
   parameter bit ASYNC_RESET = 1'b1,
   localparam int NUM_SW     = NUM_X * NUM_Y
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rb_en,
   input  logic [ROW_W-1:0]  rb_row,
   input  logic [NUM_SW-1:0] active,
   output logic [NUM_Y-1:0]  status
);

   logic [NUM_Y-1:0] row_bits;
   logic [NUM_Y-1:0] status_nx;

   assign row_bits  = active[rb_row*NUM_Y +: NUM_Y];
   assign status_nx = rb_en ? row_bits : status;

   if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status <= '0;
         else        status <= status_nx;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) status <= '0;
         else        status <= status_nx;
      end
   end

endmodule

// File: rtl/xbar_switch_ctrl.sv
module xbar_switch_ctrl
   import xbar_pkg::*;
#(
   parameter int NUM_X       = 12,
   parameter int NUM_Y       = 8,
   parameter bit ASYNC_RESET = 1'b1,
   localparam int NUM_SW     = NUM_X * NUM_Y
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cmd_word,
   input  logic              cmd_valid,
   output logic [NUM_SW-1:0] sw_active,
   output logic [NUM_Y-1:0]  status_byte
);

   if (NUM_Y != 8) begin : g_bad_y
      $error("xbar_switch_ctrl: Y count is fixed at 8 by the status byte");
   end
   if (NUM_X < 1 || NUM_X > 12) begin : g_bad_x
      $error("xbar_switch_ctrl: X count must lie in 1..12");
   end

   logic              wr_en;
   logic              wr_val;
   logic              wr_load;
   logic [ROW_W-1:0]  wr_row;
   logic [YSEL_W-1:0] wr_col;
   logic              rb_en;
   logic [ROW_W-1:0]  rb_row;

   xbar_cmd_decode i_decode (
      .word    (cmd_word),
      .valid   (cmd_valid),
      .wr_en   (wr_en),
      .wr_val  (wr_val),
      .wr_load (wr_load),
      .wr_row  (wr_row),
      .wr_col  (wr_col),
      .rb_en   (rb_en),
      .rb_row  (rb_row)
   );

   xbar_switch_bank #(
      .NUM_X       (NUM_X),
      .NUM_Y       (NUM_Y),
      .ASYNC_RESET (ASYNC_RESET)
   ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_val  (wr_val),
      .wr_load (wr_load),
      .wr_row  (wr_row),
      .wr_col  (wr_col),
      .active  (sw_active)
   );

   xbar_readback #(
      .NUM_X       (NUM_X),
      .NUM_Y       (NUM_Y),
      .ASYNC_RESET (ASYNC_RESET)
   ) i_readback (
      .clk     (clk),
      .rst_n   (rst_n),
      .rb_en   (rb_en),
      .rb_row  (rb_row),
      .active  (sw_active),
      .status  (status_byte)
   );

endmodule

// File: rtl/xbar_switch_ctrl_chk.sv
module xbar_switch_ctrl_chk #(
   parameter int NUM_X = 12,
   parameter int NUM_Y = 8
)(
   input logic                   clk,
   input logic                   rst_n,
   input logic [15:0]            cmd_word,
   input logic                   cmd_valid,
   input logic [NUM_X*NUM_Y-1:0] sw_active,
   input logic [NUM_Y-1:0]       status_byte
);

   logic [3:0] xc;
   logic       xres;
   int         sw_idx;

   assign xc     = cmd_word[14:11];
   assign xres   = (xc == 4'd6) || (xc == 4'd7) || (xc == 4'd14) || (xc == 4'd15);
   assign sw_idx = ((xc >= 4'd8) ? int'(xc) - 2 : int'(xc)) * NUM_Y + int'(cmd_word[10:8]);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEARS: assert (sw_active == '0 && status_byte == '0); // R7
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(sw_active) && $stable(status_byte))); // R11

   AST_NOLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_word[0]) |=> $stable(sw_active)); // R5

   AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && xres) |=> $stable(sw_active)); // R3

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !xres) |=> $stable(status_byte)); // R10

   AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_word[0] && !xres) |=> (sw_active[$past(sw_idx)] == $past(cmd_word[15]))); // R5

endmodule

bind xbar_switch_ctrl xbar_switch_ctrl_chk #(
   .NUM_X (NUM_X),
   .NUM_Y (NUM_Y)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_word    (cmd_word),
   .cmd_valid   (cmd_valid),
   .sw_active   (sw_active),
   .status_byte (status_byte)
);

// File: tb/test_xbar_switch_ctrl.sv
`timescale 1ns/1ps
module test_xbar_switch_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        cmd_valid = 1'b0;
   logic [95:0] sw_active;
   logic [7:0]  status_byte;

   logic [95:0] m_pend;
   logic [95:0] m_act;
   logic [7:0]  m_stat;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   xbar_switch_ctrl i_xbar_switch_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_word    (cmd_word),
      .cmd_valid   (cmd_valid),
      .sw_active   (sw_active),
      .status_byte (status_byte)
   );

   function automatic logic [7:0] rb_code(input int x);
      logic [3:0] xi = 4'(x);
      return {1'b0, xi[1], 1'b1, 1'b1, xi[0], 1'b1, xi[3:2]};
   endfunction

   function automatic logic [15:0] mk_cmd(input bit val, input int x, input int y, input bit ld);
      int code = (x < 6) ? x : x + 2;
      return {val, 4'(code), 3'(y), 7'h00, ld};
   endfunction

   task automatic model_apply(input logic [15:0] w, input bit v);
      int xc = int'(w[14:11]);
      if (!v) return;
      if (xc == 6 || xc == 7 || xc == 14 || xc == 15) begin
         for (int k = 0; k < 12; k++)
            if (w[15:8] == rb_code(k)) m_stat = m_act[k*8 +: 8];
         return;
      end
      m_pend[((xc < 8) ? xc : xc - 2) * 8 + int'(w[10:8])] = w[15];
      if (w[0]) m_act = m_pend;
   endtask

   task automatic check_out(input string tag);
      n_vec++;
      if (sw_active !== m_act) begin
         n_bad++;
         $display("FAIL %s sw_active actual %h expected %h", tag, sw_active, m_act);
      end
      if (status_byte !== m_stat) begin
         n_bad++;
         $display("FAIL %s status_byte actual %h expected %h", tag, status_byte, m_stat);
      end
   endtask

   task automatic step(input logic [15:0] w, input bit v, input string tag);
      @(negedge clk);
      cmd_word  = w;
      cmd_valid = v;
      model_apply(w, v);
      @(posedge clk);
      #1 cmd_valid = 1'b0;
      @(negedge clk);
      check_out(tag);
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n     = 1'b0;
      cmd_word  = mk_cmd(1'b1, 3, 3, 1'b1);
      cmd_valid = 1'b1;
      m_pend = '0; m_act = '0; m_stat = '0;
      @(negedge clk);
      check_out(tag);
      @(negedge clk);
      check_out(tag);
      cmd_valid = 1'b0;
      rst_n     = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1..R11 watchdog expired, actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [95:0] snap;
      logic [7:0]  st_before;
      void'($urandom(32'h5eed_2128));
      m_pend = '0; m_act = '0; m_stat = '0;
      repeat (3) @(negedge clk);
      check_out("R7 reset state");
      rst_n = 1'b1;

      // R1 R2 transparent writes at both ends of each X-code segment
      step(mk_cmd(1'b1, 0, 0, 1'b1), 1'b1, "R1 X0Y0 close");
      step(mk_cmd(1'b1, 5, 7, 1'b1), 1'b1, "R2 code5 X5Y7");
      step(mk_cmd(1'b1, 6, 2, 1'b1), 1'b1, "R2 code8 X6Y2");
      step(mk_cmd(1'b1, 11, 7, 1'b1), 1'b1, "R2 code13 X11Y7");
      step(mk_cmd(1'b0, 0, 0, 1'b1), 1'b1, "R4 open X0Y0 only");
      if (sw_active[95] !== 1'b1 || sw_active[0] !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 bit index actual %b%b expected 10", sw_active[95], sw_active[0]);
      end
      n_vec++;

      // R5 R6 latched group then one load
      snap = m_act;
      step(mk_cmd(1'b1, 1, 1, 1'b0), 1'b1, "R5 latched word1");
      step(mk_cmd(1'b1, 7, 4, 1'b0), 1'b1, "R5 latched word2");
      step(mk_cmd(1'b1, 10, 0, 1'b0), 1'b1, "R5 latched word3");
      if (sw_active !== snap) begin
         n_bad++;
         $display("FAIL R5 active moved actual %h expected %h", sw_active, snap);
      end
      n_vec++;
      step(mk_cmd(1'b1, 3, 6, 1'b1), 1'b1, "R6 group load");

      // R3 reserved X codes with pending differing from active
      step(mk_cmd(1'b1, 2, 2, 1'b0), 1'b1, "R5 pending only");
      for (int k = 0; k < 4; k++) begin
         logic [3:0] rc = (k == 0) ? 4'd6 : (k == 1) ? 4'd7 : (k == 2) ? 4'd14 : 4'd15;
         step({1'b1, rc, 3'd5, 7'h55, 1'b1}, 1'b1, "R3 reserved code with load");
      end

      // R8 readback of every row, R9 low byte with load bit ignored
      for (int x = 0; x < 12; x++)
         step({rb_code(x), 8'hFF}, 1'b1, "R8 R9 readback row");
      step({8'h3C, 8'h00}, 1'b1, "R8 literal 0x3C selects X1");
      st_before = m_stat;
      step({8'h37, 8'h01}, 1'b1, "R9 malformed select quotient 3");
      step({8'hB4, 8'h01}, 1'b1, "R9 select with bit7 set");
      if (status_byte !== st_before) begin
         n_bad++;
         $display("FAIL R9 status moved actual %h expected %h", status_byte, st_before);
      end
      n_vec++;

      // R10 status holds through writes; R11 idle
      step({rb_code(11), 8'h00}, 1'b1, "R8 row X11");
      step(mk_cmd(1'b0, 11, 7, 1'b1), 1'b1, "R10 status holds after write");
      step(mk_cmd(1'b1, 4, 4, 1'b1), 1'b0, "R11 strobe low ignored");

      // R7 reset with strobe high, then pending proven clear
      step(mk_cmd(1'b1, 9, 1, 1'b0), 1'b1, "R5 pending before reset");
      do_reset("R7 reset blocks commands");
      step(mk_cmd(1'b0, 0, 0, 1'b1), 1'b1, "R7 pending cleared by reset");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] w = 16'($urandom);
         bit          v = ($urandom % 10) < 7;
         if (($urandom % 6) == 0) w[15:8] = rb_code(int'($urandom % 12));
         step(w, v, "R1 R4 R5 R8 random");
         if (($urandom % 500) == 0) do_reset("R7 random reset");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule